// File: doc/BRIEF.md
# Data-Pin Termination and Read-Driver Sequencer

This block sits on the memory side of a double-data-rate, common-I/O synchronous SRAM port. It decides, one half clock cycle at a time, whether on-die termination on the data inputs is switched on and whether the data output drivers are enabled. Its inputs are a static termination enable and the pipelined command stream of reads, writes and no-ops. Its clock is a half-cycle tick clock, so each rising edge of `clk` is one half cycle of the memory clock. Ticks are numbered from 0, starting at the first edge after reset is released. Even ticks are the starts of the memory cycles, and commands are taken only on those ticks.

A read taken on tick t0 sends its two data beats on ticks t0+5 and t0+6, which is 2.5 cycles after the command. Data termination is switched off one tick before the first beat and stays off until one tick after the last beat. Reads placed closer together than one window merge into a single off interval. Byte-mask and clock termination simply follow the termination enable. An optional mirror output gives the enables a controller on the far end should apply. It drives where the memory terminates and terminates where the memory drives, so that the two sides can be checked against each other.

Top module: `dqs_term_seq`

## Requirements
- R1: While `rst_n` is low, every output is 0.
- R2: `mask_term_en` and `clk_term_en` equal the value `odt_en` had at the previous tick edge, whatever the command stream.
- R3: When `odt_en` was 0 at the previous edge, `dq_term_en` is 0.
- R4: With `odt_en` at 1 and only writes (`cmd_read`=0) or no-ops (`cmd_valid`=0) in the last 8 ticks, `dq_term_en` is 1.
- R5: A read (`cmd_valid`=1, `cmd_read`=1) taken on even tick t0 makes `dq_drv_en` 1 after edges t0+5 and t0+6 (two beats), and 0 otherwise when no other read is in flight.
- R6: With `odt_en` at 1, a read taken on tick t0 makes `dq_term_en` 0 after edges t0+4 through t0+7 and 1 again after edge t0+8.
- R7: Reads on consecutive cycles (ticks t0 and t0+2) keep `dq_term_en` 0 continuously from t0+4 through t0+9 and `dq_drv_en` 1 from t0+5 through t0+8.
- R8: A command presented on an odd tick is ignored: no driver window and no termination change follow it.
- R9: Reads enable the drivers on the same ticks when `odt_en` is 0.
- R10: With the mirror enabled, `ctl_drv_en` equals `dq_term_en`. `ctl_term_en` is 1 exactly when termination is enabled and the memory's data termination is off for a read. `ctl_drv_en` and `dq_drv_en` are never both 1.
- R11: `dq_term_en` and `dq_drv_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle tick clock |
| rst_n | input | 1 | Synchronous active-low reset |
| odt_en | input | 1 | Static termination enable (1 = on) |
| cmd_valid | input | 1 | Command present this tick (0 = no-op) |
| cmd_read | input | 1 | 1 = read, 0 = write, when `cmd_valid` is 1 |
| dq_term_en | output | 1 | Data-input termination enable |
| dq_drv_en | output | 1 | Data output driver enable |
| mask_term_en | output | 1 | Byte-mask input termination enable |
| clk_term_en | output | 1 | Clock input termination enable |
| ctl_drv_en | output | 1 | Mirror: controller data driver enable |
| ctl_term_en | output | 1 | Mirror: controller data termination enable |

## Verification
The assertions check the relations that must hold on every tick. Termination and drivers never overlap, and neither do the two drivers. A driver burst always lasts at least two ticks, with termination off on the tick before it starts and the tick after it ends. Mask and clock termination track the enable, and data termination is never on while the enable is off. Only the directed scenarios can show the absolute timing: that a read's window opens exactly five ticks after the command, that close reads merge into one window, and that commands on odd ticks leave no trace at all.

// File: rtl/dqs_pkg.sv
// Package: shared types and helpers for the termination sequencer.
package dqs_pkg;

    // Next-tick decisions derived from the read history.
    typedef struct packed {
        logic drv;   // memory drivers on during the next tick
        logic win;   // data termination must be off during the next tick
    } dqs_next_t;

    // History length needed to cover the latency, the burst and the trailing guard.
    function automatic int hist_len(input int lat, input int burst, input int guard);
        return lat + burst + guard - 1;
    endfunction

endpackage

// File: rtl/dqs_slot_gate.sv
// Module: dqs_slot_gate
// Tracks the half-cycle phase and passes a read strobe only on even ticks
// (cycle starts). Assumes tick 0 is the first edge after reset release.
module dqs_slot_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic cmd_read,
    output logic rd_take
);
    logic odd_q;

    // Phase toggle: 0 before even edges, 1 before odd edges.
    always_ff @(posedge clk) begin
        if (!rst_n) odd_q <= 1'b0;
        else        odd_q <= ~odd_q;
    end

    // Read accepted only at the start of a memory cycle.
    always_comb rd_take = cmd_valid & cmd_read & ~odd_q;
endmodule

// File: rtl/dqs_read_window.sv
// Module: dqs_read_window
// Shift history of accepted reads, one bit per tick. Derives the driver
// window (LAT_TICKS after the read, BURST_TICKS long) and the wider
// termination-off window (GUARD_TICKS each side). Assumes LAT_TICKS > GUARD_TICKS.
module dqs_read_window
    import dqs_pkg::*;
#(
    parameter int LAT_TICKS   = 5,
    parameter int BURST_TICKS = 2,
    parameter int GUARD_TICKS = 1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      rd_take,
    output dqs_next_t nxt
);
    localparam int HW      = hist_len(LAT_TICKS, BURST_TICKS, GUARD_TICKS);
    localparam int DRV_LO  = LAT_TICKS - 1;
    localparam int DRV_HI  = LAT_TICKS + BURST_TICKS - 2;
    localparam int WIN_LO  = LAT_TICKS - GUARD_TICKS - 1;
    localparam int WIN_HI  = HW - 1;

    logic [HW-1:0] hist_q;
    logic [HW-1:0] drv_sel;
    logic [HW-1:0] win_sel;

    // History shift: bit k set means a read was taken k+1 edges ago.
    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= {hist_q[HW-2:0], rd_take};
    end

    // Per-bit selection masks for both windows.
    for (genvar k = 0; k < HW; k++) begin : g_sel
        assign drv_sel[k] = hist_q[k] & (k >= DRV_LO) & (k <= DRV_HI);
        assign win_sel[k] = hist_q[k] & (k >= WIN_LO) & (k <= WIN_HI);
    end

    // Reduce the masks into next-tick decisions.
    always_comb begin
        nxt.drv = |drv_sel;
        nxt.win = |win_sel;
    end
endmodule

// File: rtl/dqs_enable_out.sv
// Module: dqs_enable_out
// Registers all enables so each output holds for a whole tick. Mask and
// clock termination follow the termination enable; the optional mirror
// gives the far-end controller's complementary enables.
module dqs_enable_out
    import dqs_pkg::*;
#(
    parameter bit MIRROR_EN = 1'b1
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      odt_en,
    input  dqs_next_t nxt,
    output logic      dq_term_en,
    output logic      dq_drv_en,
    output logic      mask_term_en,
    output logic      clk_term_en,
    output logic      ctl_drv_en,
    output logic      ctl_term_en
);
    logic odt_q, term_q, drv_q;

    // Memory-side enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            odt_q  <= 1'b0;
            term_q <= 1'b0;
            drv_q  <= 1'b0;
        end else begin
            odt_q  <= odt_en;
            term_q <= odt_en & ~nxt.win;
            drv_q  <= nxt.drv;
        end
    end

    assign dq_term_en   = term_q;
    assign dq_drv_en    = drv_q;
    assign mask_term_en = odt_q;
    assign clk_term_en  = odt_q;

    if (MIRROR_EN) begin : g_mirror
        logic cdrv_q, cterm_q;
        // Controller side: drive when memory terminates, terminate around reads.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cdrv_q  <= 1'b0;
                cterm_q <= 1'b0;
            end else begin
                cdrv_q  <= odt_en & ~nxt.win;
                cterm_q <= odt_en & nxt.win;
            end
        end
        assign ctl_drv_en  = cdrv_q;
        assign ctl_term_en = cterm_q;
    end else begin : g_nomirror
        assign ctl_drv_en  = 1'b0;
        assign ctl_term_en = 1'b0;
    end
endmodule

// File: rtl/dqs_term_seq.sv
// Module: dqs_term_seq (top)
// Memory-side sequencer for data termination and read drivers on a
// double-data-rate common-I/O port. Clocked at half-cycle ticks; commands
// are taken on even ticks only. Assumes odt_en is quasi-static.
module dqs_term_seq #(
    parameter int LAT_TICKS   = 5,
    parameter int BURST_TICKS = 2,
    parameter int GUARD_TICKS = 1,
    parameter bit MIRROR_EN   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic odt_en,
    input  logic cmd_valid,
    input  logic cmd_read,
    output logic dq_term_en,
    output logic dq_drv_en,
    output logic mask_term_en,
    output logic clk_term_en,
    output logic ctl_drv_en,
    output logic ctl_term_en
);
    import dqs_pkg::*;

    logic      rd_take;
    dqs_next_t nxt;

    dqs_slot_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_read  (cmd_read),
        .rd_take   (rd_take)
    );

    dqs_read_window #(
        .LAT_TICKS   (LAT_TICKS),
        .BURST_TICKS (BURST_TICKS),
        .GUARD_TICKS (GUARD_TICKS)
    ) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_take (rd_take),
        .nxt     (nxt)
    );

    dqs_enable_out #(
        .MIRROR_EN (MIRROR_EN)
    ) u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .odt_en       (odt_en),
        .nxt          (nxt),
        .dq_term_en   (dq_term_en),
        .dq_drv_en    (dq_drv_en),
        .mask_term_en (mask_term_en),
        .clk_term_en  (clk_term_en),
        .ctl_drv_en   (ctl_drv_en),
        .ctl_term_en  (ctl_term_en)
    );
endmodule

// File: rtl/dqs_term_seq_chk.sv
// Module: dqs_term_seq_chk
// Per-tick protocol checks on the sequencer's ports, bound into the top.
module dqs_term_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic odt_en,
    input logic dq_term_en,
    input logic dq_drv_en,
    input logic mask_term_en,
    input logic clk_term_en,
    input logic ctl_drv_en
);
    logic live_q;

    // Marks ticks that have a full tick of history since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    assert_term_drv_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_term_en && dq_drv_en));

    assert_drv_no_clash_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(dq_drv_en && ctl_drv_en));

    assert_mask_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (mask_term_en == $past(odt_en)) && (clk_term_en == $past(odt_en)));

    assert_term_needs_odt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dq_term_en |-> mask_term_en);

    assert_two_beats_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drv_en) |=> dq_drv_en);

    assert_lead_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dq_drv_en) |-> !$past(dq_term_en));

    assert_trail_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dq_drv_en) |-> !dq_term_en);
endmodule

bind dqs_term_seq dqs_term_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .odt_en       (odt_en),
    .dq_term_en   (dq_term_en),
    .dq_drv_en    (dq_drv_en),
    .mask_term_en (mask_term_en),
    .clk_term_en  (clk_term_en),
    .ctl_drv_en   (ctl_drv_en)
);

// File: tb/sim_dqs_term_seq.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, outputs sampled at the falling edge.
module sim_dqs_term_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic odt_en = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_read = 1'b0;
    logic dq_term_en, dq_drv_en, mask_term_en, clk_term_en, ctl_drv_en, ctl_term_en;

    int checks = 0;
    int errors = 0;
    int edge_no = -1;
    logic m_odt = 1'b0;
    int rd_q[$];

    always #2 clk = ~clk;

    dqs_term_seq u0 (
        .clk(clk), .rst_n(rst_n), .odt_en(odt_en),
        .cmd_valid(cmd_valid), .cmd_read(cmd_read),
        .dq_term_en(dq_term_en), .dq_drv_en(dq_drv_en),
        .mask_term_en(mask_term_en), .clk_term_en(clk_term_en),
        .ctl_drv_en(ctl_drv_en), .ctl_term_en(ctl_term_en)
    );

    // Bench tick index and the enable value each edge saw.
    always @(posedge clk) begin
        if (rst_n) edge_no <= edge_no + 1;
        m_odt <= odt_en;
    end

    task automatic cmp(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s at tick %0d: actual %0b expected %0b", tag, what, edge_no, act, exp);
        end
    endtask

    // Compare every output after the latest edge against the requirement model.
    task automatic check_tick(input string tag);
        logic e_drv, e_win, e_term;
        e_drv = 1'b0; e_win = 1'b0;
        foreach (rd_q[i]) begin
            int d;
            d = edge_no - rd_q[i];
            if (d >= 5 && d <= 6) e_drv = 1'b1;
            if (d >= 4 && d <= 7) e_win = 1'b1;
        end
        e_term = m_odt & ~e_win;
        cmp(tag, "dq_drv_en", dq_drv_en, e_drv);
        cmp(tag, "dq_term_en", dq_term_en, e_term);
        cmp("R2", "mask_term_en", mask_term_en, m_odt);
        cmp("R2", "clk_term_en", clk_term_en, m_odt);
        cmp("R10", "ctl_drv_en", ctl_drv_en, e_term);
        cmp("R10", "ctl_term_en", ctl_term_en, m_odt & e_win);
        cmp("R11", "term/drv overlap", dq_term_en & dq_drv_en, 1'b0);
    endtask

    task automatic step(input string tag);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_read  = 1'b0;
        check_tick(tag);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(tag);
    endtask

    // Present a command on the next even tick (odd when want_odd is set).
    task automatic issue(input logic v, input logic rd, input bit want_odd, input string tag);
        if ((((edge_no + 1) % 2) == 1) != want_odd) step(tag);
        cmd_valid = v;
        cmd_read  = rd;
        if (v && rd && !want_odd) rd_q.push_back(edge_no + 1);
        step(tag);
    endtask

    task automatic sc_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        cmp("R1", "dq_term_en", dq_term_en, 1'b0);
        cmp("R1", "dq_drv_en", dq_drv_en, 1'b0);
        cmp("R1", "mask_term_en", mask_term_en, 1'b0);
        cmp("R1", "ctl_drv_en", ctl_drv_en, 1'b0);
        cmp("R1", "ctl_term_en", ctl_term_en, 1'b0);
        odt_en = 1'b1;
        @(negedge clk);
        cmp("R1", "clk_term_en", clk_term_en, 1'b0);
        odt_en = 1'b0;
        rst_n = 1'b1;
    endtask

    task automatic sc_idle_writes;  // R4 and R2
        odt_en = 1'b1;
        run(2, "R2");
        issue(1'b1, 1'b0, 1'b0, "R4");
        issue(1'b0, 1'b1, 1'b0, "R4");
        issue(1'b1, 1'b0, 1'b0, "R4");
        run(8, "R4");
        cmp("R4", "dq_term_en steady", dq_term_en, 1'b1);
    endtask

    task automatic sc_single_read;  // R5 and R6
        issue(1'b1, 1'b1, 1'b0, "R6");
        run(10, "R5");
    endtask

    task automatic sc_back_to_back;  // R7
        issue(1'b1, 1'b1, 1'b0, "R7");
        issue(1'b1, 1'b1, 1'b0, "R7");
        run(12, "R7");
    endtask

    task automatic sc_odd_slot;  // R8
        issue(1'b1, 1'b1, 1'b1, "R8");
        run(10, "R8");
        cmp("R8", "no driver window", dq_drv_en, 1'b0);
    endtask

    task automatic sc_odt_off;  // R3 and R9
        odt_en = 1'b0;
        run(2, "R3");
        issue(1'b1, 1'b1, 1'b0, "R9");
        run(10, "R9");
        cmp("R3", "dq_term_en with enable off", dq_term_en, 1'b0);
        odt_en = 1'b1;
        run(3, "R2");
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        sc_reset();
        sc_idle_writes();
        sc_single_read();
        sc_back_to_back();
        sc_odd_slot();
        sc_odt_off();
        sc_single_read();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule